// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block holds the storage array of a byte-wide boot-block flash device and the command interpreter in front of it. It sits on a simple synchronous byte bus with an address, write data, a write strobe, a read strobe and registered read data. A write is taken as a command byte unless an erase or program sequence is waiting for its second write. The command selects what later reads return: array contents, identifier codes or the status byte. Two-write sequences program a single byte or erase a whole block.

The address space is cut into thirty-two equal segments. These form one large main block, two small parameter blocks of one segment each, and a two-segment boot block that can never be programmed or erased. `BOTTOM` places the boot block at the bottom of the space and `INV_HI` XORs the top address bit on every access. `AW` sets the array depth, and every block boundary scales with it. An erase writes 0xFF one byte per clock while `busy` is high, and writes sent during that time are dropped.

Top module: `bootflash_ctrl`

## Requirements
- R1: After reset `busy` is 0, the status byte is 0x00 and the device is in array-read mode.
- R2: After command 0x90, a read at an even address returns 0x89. A read at an odd address returns 0x94 when `BOTTOM`=0 and 0x95 when `BOTTOM`=1.
- R3: After command 0x70, every read returns the status byte whatever the address. The status byte is only ever 0x00 or 0x80. Command 0x50 sets the status to 0x00 and selects array-read mode.
- R4: A write of 0x40 or 0x10 followed by a second write stores the second write's data at its address. The status becomes 0x80 and the device enters status-read mode.
- R5: The program write is dropped when its address lies in the boot block. The status still becomes 0x80.
- R6: A write of 0x20 followed by a write of 0xD0 fills the block that holds the second address with 0xFF. The fill runs one byte per clock, so `busy` is high for exactly the block length in cycles. Status bit 7 reads 0 while busy and the status is 0x80 afterwards. The device is then in status-read mode.
- R7: A write of 0x20 followed by any data other than 0xD0 changes no array byte and leaves the status unchanged. The device still enters status-read mode.
- R8: An erase confirm aimed at the boot block changes no byte, raises no `busy`, and sets the status to 0x80.
- R9: Segment index is the top five address bits. With `BOTTOM`=0: segments 0-27 are main, 28 and 29 are the parameter blocks, and 30-31 are boot. With `BOTTOM`=1: segments 0-1 are boot, 2 and 3 are the parameter blocks, and 4-31 are main. An erase touches only its own block.
- R10: With `INV_HI`=1, address bit AW-1 is inverted before any decode, array access or boot check.
- R11: While `busy` is high, bus writes are ignored and do not change the mode.
- R12: Any other command byte, including 0xFF, 0x50 and 0xD0, selects array-read mode. `rdata` updates on the clock edge that samples `rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data or command byte |
| wr | input | 1 | Write strobe, one byte per cycle |
| rd | input | 1 | Read strobe; `rdata` loads on the same edge |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | High while an erase fill is running |

## Verification
On every cycle the assertions check several invariants. Neither program nor erase ever writes a boot-block address, erase writes carry 0xFF, and the status holds one of its two legal values with bit 7 clear while busy. Each setup write leads to status mode, and writes during busy leave the mode alone. Only the bench's scenarios can show the rest: which bytes actually change, the exact busy length per block, the identifier codes, the effect of address inversion on a full readback, and the mode left behind by unknown commands. The bench runs the top-boot plain layout and the bottom-boot inverted layout side by side against an arithmetic model of both.

// File: rtl/bf_pkg.sv
package bf_pkg;

  typedef enum logic [2:0] {
    MD_ARRAY,
    MD_IDENT,
    MD_STATUS,
    MD_ERASE_SETUP,
    MD_PROG_SETUP
  } bf_mode_t;

  typedef enum logic [1:0] {
    BK_MAIN,
    BK_PARAM_A,
    BK_PARAM_B,
    BK_BOOT
  } bf_block_t;

  localparam logic [7:0] OP_ARRAY    = 8'hFF;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_CLEAR    = 8'h50;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_PROG     = 8'h40;
  localparam logic [7:0] OP_PROG_ALT = 8'h10;

  localparam logic [7:0] MFR_CODE    = 8'h89;
  localparam logic [7:0] DEV_TOP     = 8'h94;
  localparam logic [7:0] DEV_BOTTOM  = 8'h95;
  localparam logic [7:0] ST_READY    = 8'h80;
  localparam logic [7:0] ST_IDLE     = 8'h00;

  // Mode chosen by a command byte written outside a setup sequence.
  function automatic bf_mode_t decode_cmd(input logic [7:0] c);
    case (c)
      OP_IDENT:            return MD_IDENT;
      OP_STATUS:           return MD_STATUS;
      OP_ERASE:            return MD_ERASE_SETUP;
      OP_PROG, OP_PROG_ALT: return MD_PROG_SETUP;
      default:             return MD_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/bf_blockmap.sv
module bf_blockmap
  import bf_pkg::*;
#(
  parameter int AW     = 11,
  parameter int BOTTOM = 0
) (
  input  logic [AW-1:0] addr,
  output bf_block_t     kind,
  output logic [AW-1:0] first,
  output logic [AW-1:0] last
);
  localparam int SEGW = AW - 5;

  logic [4:0] seg;
  assign seg = addr[AW-1:SEGW];

  function automatic logic [AW-1:0] seg_lo(input logic [4:0] s);
    return {s, {SEGW{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] seg_hi(input logic [4:0] s);
    return {s, {SEGW{1'b1}}};
  endfunction

  generate
    if (BOTTOM != 0) begin : g_bottom
      always_comb begin
        if (seg < 5'd2) begin
          kind = BK_BOOT;    first = seg_lo(5'd0);  last = seg_hi(5'd1);
        end else if (seg == 5'd2) begin
          kind = BK_PARAM_A; first = seg_lo(5'd2);  last = seg_hi(5'd2);
        end else if (seg == 5'd3) begin
          kind = BK_PARAM_B; first = seg_lo(5'd3);  last = seg_hi(5'd3);
        end else begin
          kind = BK_MAIN;    first = seg_lo(5'd4);  last = seg_hi(5'd31);
        end
      end
    end else begin : g_top
      always_comb begin
        if (seg < 5'd28) begin
          kind = BK_MAIN;    first = seg_lo(5'd0);  last = seg_hi(5'd27);
        end else if (seg == 5'd28) begin
          kind = BK_PARAM_A; first = seg_lo(5'd28); last = seg_hi(5'd28);
        end else if (seg == 5'd29) begin
          kind = BK_PARAM_B; first = seg_lo(5'd29); last = seg_hi(5'd29);
        end else begin
          kind = BK_BOOT;    first = seg_lo(5'd30); last = seg_hi(5'd31);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bf_eraser.sv
module bf_eraser #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  output logic          busy,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          done
);
  logic [AW-1:0] ptr;
  logic [AW-1:0] stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
      stop <= '0;
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= first;
      stop <= last;
    end else if (busy) begin
      if (ptr == stop) busy <= 1'b0;
      else             ptr  <= ptr + 1'b1;
    end
  end

  assign we    = busy;
  assign waddr = ptr;
  assign done  = busy && (ptr == stop);

endmodule

// File: rtl/bf_array.sv
module bf_array #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/bootflash_ctrl.sv
module bootflash_ctrl
  import bf_pkg::*;
#(
  parameter int AW     = 11,
  parameter int BOTTOM = 0,
  parameter int INV_HI = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          wr,
  input  logic          rd,
  output logic [7:0]    rdata,
  output logic          busy
);
  localparam logic [AW-1:0] HI_MASK = {(INV_HI != 0), {(AW-1){1'b0}}};
  localparam logic [7:0]    DEV_CODE = (BOTTOM != 0) ? DEV_BOTTOM : DEV_TOP;

  bf_mode_t      mode_q;
  logic [7:0]    status_q;
  logic [AW-1:0] eff_addr;
  bf_block_t     kind;
  logic [AW-1:0] blk_first, blk_last;

  // Named internal events
  logic          wr_ok, erase_go, prog_we;
  logic          er_we, er_done;
  logic [AW-1:0] er_addr;
  logic          arr_we;
  logic [AW-1:0] arr_waddr;
  logic [7:0]    arr_wdata, arr_rdata;

  assign eff_addr = addr ^ HI_MASK;

  bf_blockmap #(.AW(AW), .BOTTOM(BOTTOM)) u_map (
    .addr (eff_addr),
    .kind (kind),
    .first(blk_first),
    .last (blk_last)
  );

  assign wr_ok    = wr && !busy;
  assign erase_go = wr_ok && (mode_q == MD_ERASE_SETUP) &&
                    (wdata == OP_CONFIRM) && (kind != BK_BOOT);
  assign prog_we  = wr_ok && (mode_q == MD_PROG_SETUP) && (kind != BK_BOOT);

  bf_eraser #(.AW(AW)) u_eraser (
    .clk  (clk),
    .rst_n(rst_n),
    .start(erase_go),
    .first(blk_first),
    .last (blk_last),
    .busy (busy),
    .we   (er_we),
    .waddr(er_addr),
    .done (er_done)
  );

  assign arr_we    = er_we || prog_we;
  assign arr_waddr = er_we ? er_addr : eff_addr;
  assign arr_wdata = er_we ? 8'hFF   : wdata;

  bf_array #(.AW(AW)) u_array (
    .clk  (clk),
    .we   (arr_we),
    .waddr(arr_waddr),
    .wdata(arr_wdata),
    .raddr(eff_addr),
    .rdata(arr_rdata)
  );

  // Command and status state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_ARRAY;
      status_q <= ST_IDLE;
    end else if (wr_ok) begin
      case (mode_q)
        MD_ERASE_SETUP: begin
          mode_q <= MD_STATUS;
          if (wdata == OP_CONFIRM)
            status_q <= (kind == BK_BOOT) ? ST_READY : ST_IDLE;
        end
        MD_PROG_SETUP: begin
          mode_q   <= MD_STATUS;
          status_q <= ST_READY;
        end
        default: begin
          mode_q <= decode_cmd(wdata);
          if (wdata == OP_CLEAR) status_q <= ST_IDLE;
        end
      endcase
    end else if (er_done) begin
      status_q <= ST_READY;
    end
  end

  // Registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 8'h00;
    end else if (rd) begin
      case (mode_q)
        MD_IDENT:  rdata <= eff_addr[0] ? DEV_CODE : MFR_CODE;
        MD_STATUS: rdata <= status_q;
        default:   rdata <= arr_rdata;
      endcase
    end
  end

endmodule

// File: rtl/bf_checker.sv
module bf_checker
  import bf_pkg::*;
#(
  parameter int AW     = 11,
  parameter int BOTTOM = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic          busy,
  input logic [7:0]    status_q,
  input bf_mode_t      mode_q,
  input logic          arr_we,
  input logic [AW-1:0] arr_waddr,
  input logic [7:0]    arr_wdata,
  input logic          er_we
);
  // Boot block is the top or bottom sixteenth of the array.
  logic in_boot;
  assign in_boot = (BOTTOM != 0) ? (arr_waddr[AW-1:AW-4] == 4'h0)
                                 : (arr_waddr[AW-1:AW-4] == 4'hF);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r1: assert (status_q == 8'h00 && !busy && mode_q == MD_ARRAY)
        else $error("reset state wrong");
    end
  end

  p_status_codes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 8'h00) || (status_q == 8'h80));

  p_setup_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !busy && (mode_q == MD_PROG_SETUP || mode_q == MD_ERASE_SETUP))
      |=> (mode_q == MD_STATUS));

  p_prog_skip_boot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !er_we) |-> !in_boot);

  p_erase_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    er_we |-> (arr_wdata == 8'hFF));

  p_busy_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !status_q[7]);

  p_erase_skip_boot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    er_we |-> !in_boot);

  p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr) |=> (mode_q == $past(mode_q)));

endmodule

bind bootflash_ctrl bf_checker #(.AW(AW), .BOTTOM(BOTTOM)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr       (wr),
  .busy     (busy),
  .status_q (status_q),
  .mode_q   (mode_q),
  .arr_we   (arr_we),
  .arr_waddr(arr_waddr),
  .arr_wdata(arr_wdata),
  .er_we    (er_we)
);

// File: tb/bootflash_ctrl_test.sv
module bootflash_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int SEG = DEPTH / 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata0, rdata1;
  logic busy0, busy1;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Device 0: top boot, no inversion. Device 1: bottom boot, MSB inverted.
  bootflash_ctrl #(.AW(AW), .BOTTOM(0), .INV_HI(0)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata0), .busy(busy0));
  bootflash_ctrl #(.AW(AW), .BOTTOM(1), .INV_HI(1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata1), .busy(busy1));

  int nchecks = 0, nerrors = 0;
  bit finished = 0;
  int bcnt [2];

  always @(posedge clk) begin
    if (busy0) bcnt[0]++;
    if (busy1) bcnt[1]++;
  end

  // Model state: 0 array, 1 ident, 2 status, 3 erase setup, 4 program setup
  int mmode [2];
  logic [7:0] mstat [2];
  logic [7:0] mmem [2][DEPTH];
  bit mknown [2][DEPTH];
  int explen [2];

  function automatic int phys(int d, int a);
    return (d != 0) ? (a ^ (DEPTH/2)) : a;
  endfunction

  // 0 main, 1 param A, 2 param B, 3 boot
  function automatic int blk(int d, int p);
    int s = p / SEG;
    if (d == 0) return (s < 28) ? 0 : (s == 28) ? 1 : (s == 29) ? 2 : 3;
    return (s < 2) ? 3 : (s == 2) ? 1 : (s == 3) ? 2 : 0;
  endfunction

  function automatic int bfirst(int d, int b);
    if (d == 0) return (b == 0) ? 0 : (b == 1) ? 28*SEG : (b == 2) ? 29*SEG : 30*SEG;
    return (b == 3) ? 0 : (b == 1) ? 2*SEG : (b == 2) ? 3*SEG : 4*SEG;
  endfunction

  function automatic int blen(int d, int b);
    if (b == 0) return 28*SEG;
    if (b == 3) return 2*SEG;
    return SEG;
  endfunction

  task automatic chk(input string tag, input int d, input int got, input int exp);
    nchecks++;
    if (got != exp) begin
      nerrors++;
      $display("FAIL %s dev%0d: actual %0h expected %0h", tag, d, got, exp);
    end
  endtask

  task automatic model_write(input int a, input int v);
    for (int d = 0; d < 2; d++) begin
      int p = phys(d, a);
      int b = blk(d, p);
      explen[d] = 0;
      case (mmode[d])
        3: begin
          mmode[d] = 2;
          if (v == 8'hD0) begin
            if (b != 3) begin
              for (int i = bfirst(d, b); i < bfirst(d, b) + blen(d, b); i++) begin
                mmem[d][i] = 8'hFF; mknown[d][i] = 1;
              end
              explen[d] = blen(d, b);
            end
            mstat[d] = 8'h80;
          end
        end
        4: begin
          mmode[d] = 2;
          mstat[d] = 8'h80;
          if (b != 3) begin mmem[d][p] = v[7:0]; mknown[d][p] = 1; end
        end
        default: begin
          case (v)
            8'h90: mmode[d] = 1;
            8'h70: mmode[d] = 2;
            8'h20: mmode[d] = 3;
            8'h40, 8'h10: mmode[d] = 4;
            default: mmode[d] = 0;
          endcase
          if (v == 8'h50) mstat[d] = 8'h00;
        end
      endcase
    end
  endtask

  task automatic bus_write(input int a, input int v, input bit ignored);
    addr = a[AW-1:0]; wdata = v[7:0]; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (!ignored) model_write(a, v);
  endtask

  task automatic bus_read(input int a, output int r0, output int r1);
    addr = a[AW-1:0]; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    r0 = rdata0; r1 = rdata1;
  endtask

  task automatic read_check(input int a, input string tag);
    int r [2];
    bus_read(a, r[0], r[1]);
    for (int d = 0; d < 2; d++) begin
      if (mmode[d] == 1)
        chk(tag, d, r[d], (a % 2 == 1) ? ((d != 0) ? 8'h95 : 8'h94) : 8'h89);
      else if (mmode[d] == 2)
        chk(tag, d, r[d], mstat[d]);
      else begin
        int p = phys(d, a);
        if (mknown[d][p]) chk(tag, d, r[d], mmem[d][p]);
        else begin mmem[d][p] = r[d][7:0]; mknown[d][p] = 1; end
      end
    end
  endtask

  task automatic wait_idle();
    while (busy0 || busy1) @(negedge clk);
  endtask

  task automatic do_erase(input int a, input int v, input string tag);
    int c0, c1;
    bus_write(a, 8'h20, 0);
    c0 = bcnt[0]; c1 = bcnt[1];
    bus_write(a, v, 0);
    wait_idle();
    chk(tag, 0, bcnt[0] - c0, explen[0]);
    chk(tag, 1, bcnt[1] - c1, explen[1]);
  endtask

  task automatic sweep(input string tag);
    bus_write(0, 8'hFF, 0);
    for (int a = 0; a < DEPTH; a++) read_check(a, tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nchecks++; nerrors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int r0, r1;
    for (int d = 0; d < 2; d++) begin
      mmode[d] = 0; mstat[d] = 8'h00; explen[d] = 0;
      for (int i = 0; i < DEPTH; i++) mknown[d][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", 0, busy0, 0);
    chk("R1 busy", 1, busy1, 0);
    bus_write(5, 8'h70, 0);
    read_check(5, "R1 status");

    // R9 R6: erase every segment in turn, lengths checked per layout
    for (int s = 0; s < 32; s++) do_erase(s * SEG + 3, 8'hD0, "R6 R9 erase length");
    read_check(17, "R6 status after erase");
    sweep("R6 R9 R10 erased readback");

    // R2: identifier codes
    bus_write(0, 8'h90, 0);
    for (int a = 0; a < 8; a++) read_check(a, "R2 ident");
    read_check(DEPTH - 1, "R2 ident high");
    read_check(DEPTH / 2, "R2 ident mid");

    // R4 R5 R10: program sweep across all blocks, both program opcodes
    for (int a = 0; a < DEPTH; a += 5) begin
      bus_write(a, (a % 2 == 1) ? 8'h10 : 8'h40, 0);
      bus_write(a, (a * 7 + 3) & 255, 0);
      if (a % 50 == 0) read_check(a ^ 3, "R4 status after program");
    end
    sweep("R4 R5 R10 program readback");

    // R7: erase setup with non-confirm data
    bus_write(40, 8'h50, 0);
    do_erase(40, 8'h33, "R7 no busy");
    read_check(40, "R7 status unchanged");
    sweep("R7 contents unchanged");

    // R3: status on any address, clear status
    bus_write(9, 8'h70, 0);
    for (int a = 0; a < DEPTH; a += 37) read_check(a, "R3 status any address");
    bus_write(9, 8'h50, 0);
    read_check(10, "R3 clear selects array");
    bus_write(9, 8'h70, 0);
    read_check(11, "R3 cleared status");

    // R6 R11: read and write during busy
    bus_write(28 * SEG, 8'h20, 0);
    bus_write(28 * SEG, 8'hD0, 0);
    bus_read(7, r0, r1);
    chk("R6 busy status", 0, r0, 8'h00);
    chk("R6 busy status", 1, r1, 8'h00);
    bus_write(7, 8'hFF, 1);
    bus_write(7, 8'h90, 1);
    wait_idle();
    read_check(7, "R11 write ignored while busy");
    sweep("R9 neighbours intact");

    // R8: erase aimed at the top-layout boot block
    bus_write(0, 8'h50, 0);
    do_erase(30 * SEG + 1, 8'hD0, "R8 boot erase busy");
    read_check(0, "R8 status ready");
    sweep("R8 boot unchanged");

    // R12: unknown commands select array mode
    bus_write(0, 8'h12, 0);
    read_check(20, "R12 unknown cmd");
    bus_write(0, 8'h70, 0);
    bus_write(0, 8'hD0, 0);
    read_check(25, "R12 lone confirm");

    finished = 1;
    summary();
    $finish;
  end

endmodule